// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a bus-mapped watchdog for a larger chip. A source clock feeds a programmable prescaler and then a power-of-two divider. Each time the pair completes a period, a down-counter takes one step. Software keeps the system alive by writing a fresh value into the live counter before it runs out.

When the counter is already at zero and another step arrives, the block reloads the counter from the reload register and keeps running. On that same step it can send a single-cycle reset request, latch an interrupt that stays pending, or do both. A write of any value to the clear register drops the pending interrupt.

A debug-acknowledge input can hide both outputs while the chip is halted for debug, but only if the control word allows this. The counter width is a parameter and is either 16 or 32 bits.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the control word reads 0x0000_8021: counting on, reset request on, interrupt off, divider code 0, prescaler 0x80, debug mask off. The reload and counter registers both read 0x8000, and neither output is asserted.
- R2: Word address 0 is the control word, 1 is the reload value, 2 is the live count and 3 is the interrupt clear. Control bits used: reset enable [0], interrupt enable [2], divider code [4:3], counting enable [5], prescaler [15:8] and debug mask [16]. All other control bits read zero, and address 3 always reads zero.
- R3: While counting is on, the counter steps down once every (P+1)·D clock cycles. P is control[15:8], and D is 16, 32, 64 or 128 for divider code 0, 1, 2 or 3. The first step comes exactly (P+1)·D cycles after the counter register is written.
- R4: A write to the reload register does not change the running count. The new reload value takes effect at the next terminal step.
- R5: A step that finds the count at zero is a terminal step. It loads the count from the reload register, and counting carries on from there.
- R6: If control[0] is set, the reset request is high for exactly the one cycle after each terminal step. If control[0] is clear, the reset request stays low.
- R7: If control[2] is set, a terminal step sets the interrupt pending flag, and irq_o is high while the flag is set. The flag stays set until a write to address 3, whatever the data. If a terminal step and a clear write land on the same edge, the flag is set.
- R8: While control[16] and dbg_ack are both high, irq_o and rst_req_o are held low. A pending interrupt is kept and shows again when the mask lifts.
- R9: With control[5] clear, the count holds its value and the prescaler and divider stages are held cleared. After counting is turned back on, the first step comes (P+1)·D cycles later.
- R10: The counter and reload registers are CNT_W bits wide (16 by default). Writes keep the low CNT_W bits, so the full-scale value reads back as 0xFFFF in the default build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dbg_ack | input | 1 | High while the chip is halted for debug |
| irq_o | output | 1 | Interrupt, level, high while pending and unmasked |
| rst_req_o | output | 1 | Reset request, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a clear write that lands on the very edge of a terminal step, because the bus write has to meet an internal event at an exact cycle. The bench gets there by loading the counter with zero, which restarts the stage chain from a known state. It then counts (P+1)·D−1 edges with P=0 and D=16 and issues the clear so that it commits on the terminal edge. The debug mask case is reached by raising dbg_ack across a terminal step and then dropping it, which shows that the pending flag survived.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BUS_W       = 32;
    localparam int ADDR_W      = 2;
    localparam int PRE_W       = 8;
    localparam int SEL_W       = 2;
    localparam int DIV_LOG_MIN = 4;
    localparam int DIV_CNT_W   = DIV_LOG_MIN + (1 << SEL_W) - 1;

    // control word bit positions (software-visible layout)
    localparam int POS_RST = 0;
    localparam int POS_IRQ = 2;
    localparam int POS_DIV = 3;
    localparam int POS_RUN = 5;
    localparam int POS_PRE = 8;
    localparam int POS_DBG = 16;

    localparam logic [BUS_W-1:0] LOAD_INIT = 32'h0000_8000;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_ICLR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             dbg_mask;
        logic [PRE_W-1:0] presc;
        logic             run;
        logic [SEL_W-1:0] div_sel;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    localparam ctrl_t CTRL_INIT = '{dbg_mask: 1'b0, presc: 8'h80, run: 1'b1,
                                    div_sel: 2'd0, irq_en: 1'b0, rst_en: 1'b1};

    function automatic logic [BUS_W-1:0] ctrl_pack(ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[POS_RST]              = c.rst_en;
        w[POS_IRQ]              = c.irq_en;
        w[POS_DIV +: SEL_W]     = c.div_sel;
        w[POS_RUN]              = c.run;
        w[POS_PRE +: PRE_W]     = c.presc;
        w[POS_DBG]              = c.dbg_mask;
        return w;
    endfunction

    // last divider index for a code: D-1 where D = 16 << code
    function automatic logic [DIV_CNT_W-1:0] div_last(logic [SEL_W-1:0] code);
        int unsigned len;
        len = 32'd1 << (DIV_LOG_MIN + int'(code));
        return DIV_CNT_W'(len - 32'd1);
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [BUS_W-1:0]  rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              cnt_load,
    output logic              iclr
);
    localparam int PAD = BUS_W - CNT_W;

    reg_sel_e         sel;
    logic [BUS_W-1:0] reload_w;
    logic [BUS_W-1:0] count_w;
    logic             unused_wbits;

    assign sel          = reg_sel_e'(addr);
    assign cnt_load     = wr_en && (sel == SEL_COUNT);
    assign iclr         = wr_en && (sel == SEL_ICLR);
    assign unused_wbits = ^{wdata[1], wdata[7:6], wdata[BUS_W-1:17]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_INIT;
            reload <= CNT_W'(LOAD_INIT);
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    ctrl.rst_en   <= wdata[POS_RST];
                    ctrl.irq_en   <= wdata[POS_IRQ];
                    ctrl.div_sel  <= wdata[POS_DIV +: SEL_W];
                    ctrl.run      <= wdata[POS_RUN];
                    ctrl.presc    <= wdata[POS_PRE +: PRE_W];
                    ctrl.dbg_mask <= wdata[POS_DBG];
                end
                SEL_RELOAD: reload <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    generate
        if (PAD > 0) begin : g_pad
            assign reload_w = {{PAD{1'b0}}, reload};
            assign count_w  = {{PAD{1'b0}}, cnt_val};
        end else begin : g_full
            assign reload_w = reload;
            assign count_w  = cnt_val;
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_CTRL:   rdata = ctrl_pack(ctrl);
            SEL_RELOAD: rdata = reload_w;
            SEL_COUNT:  rdata = count_w;
            default:    rdata = '0;
        endcase
    end

    // R2: a write to a register other than the control word leaves it unchanged
    assert_ctrl_only_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || sel != SEL_CTRL) |=> $stable(ctrl));

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] presc,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0]     pre_cnt;
    logic [DIV_CNT_W-1:0] div_cnt;
    logic                 pre_hit;

    assign pre_hit = run && (pre_cnt >= presc);
    assign tick    = pre_hit && (div_cnt >= div_last(div_sel));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_hit) begin
            pre_cnt <= '0;
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R3: the shortest step period is 16 cycles, so steps never come back to back
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R9: once the chain is held cleared, no step follows on the next cycle
    assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             terminal
);
    logic at_zero;

    assign at_zero  = (cnt == '0);
    assign terminal = tick && at_zero && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_W'(LOAD_INIT);
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= at_zero ? reload : cnt - 1'b1;
        end
    end

    // R3: a normal step lowers the count by one
    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !at_zero && !load) |=> cnt == CNT_W'($past(cnt) - 1'b1));

    // R5: a terminal step reloads
    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        terminal |=> cnt == $past(reload));

    // R9: with no step and no write, the count holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/wdog_outputs.sv
module wdog_outputs (
    input  logic clk,
    input  logic rst,
    input  logic terminal,
    input  logic rst_en,
    input  logic irq_en,
    input  logic dbg_mask,
    input  logic dbg_ack,
    input  logic iclr,
    output logic irq_o,
    output logic rst_req_o
);
    logic rst_q;
    logic pend;
    logic hide;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            rst_q <= terminal && rst_en;
            if (terminal && irq_en) begin
                pend <= 1'b1;
            end else if (iclr) begin
                pend <= 1'b0;
            end
        end
    end

    assign hide      = dbg_mask && dbg_ack;
    assign irq_o     = pend && !hide;
    assign rst_req_o = rst_q && !hide;

    // R6: the reset request lasts one cycle
    assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rst_q |=> !rst_q);

    // R7: pending stays set until a clear write
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (pend && !iclr) |=> pend);

    // R7: an enabled terminal step always leaves the flag set
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (terminal && irq_en) |=> pend);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              dbg_ack,
    output logic              irq_o,
    output logic              rst_req_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             cnt_load;
    logic             iclr;
    logic             tick;
    logic             terminal;
    logic             restart;

    assign restart = !ctrl.run || cnt_load;

    wdog_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cnt_val  (cnt),
        .rdata    (bus_rdata),
        .ctrl     (ctrl),
        .reload   (reload),
        .cnt_load (cnt_load),
        .iclr     (iclr)
    );

    wdog_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run),
        .restart (restart),
        .presc   (ctrl.presc),
        .div_sel (ctrl.div_sel),
        .tick    (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .reload   (reload),
        .cnt      (cnt),
        .terminal (terminal)
    );

    wdog_outputs u_out (
        .clk       (clk),
        .rst       (rst),
        .terminal  (terminal),
        .rst_en    (ctrl.rst_en),
        .irq_en    (ctrl.irq_en),
        .dbg_mask  (ctrl.dbg_mask),
        .dbg_ack   (dbg_ack),
        .iclr      (iclr),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    // R4: a reload write alone never moves the live count
    assert_reload_write_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == SEL_RELOAD && !tick) |=> $stable(cnt));

    // R2: the clear address always reads zero
    assert_iclr_read_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == SEL_ICLR) |-> bus_rdata == '0);

endmodule

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_ack = 1'b0;
    logic        irq_o;
    logic        rst_req_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wdog_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_ack   (dbg_ack),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    localparam logic [1:0] A_CTRL = 2'd0, A_RLD = 2'd1, A_CNT = 2'd2, A_CLR = 2'd3;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_edges(int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0000_8021);
        rd(A_RLD, d);  chk("R1 reload", d, 32'h0000_8000);
        rd(A_CNT, d);  chk("R1 count", d, 32'h0000_8000);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 rst_req", {31'd0, rst_req_o}, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); chk("R2 ctrl mask", d, 32'h0001_FF3D);
        wr(A_RLD, 32'hFFFF_FFFF);
        rd(A_RLD, d);  chk("R10 reload width", d, 32'h0000_FFFF);
        wr(A_CNT, 32'hFFFF_FFFF);
        rd(A_CNT, d);  chk("R10 count width", d, 32'h0000_FFFF);
        rd(A_CLR, d);  chk("R2 clear reads zero", d, 32'd0);
        wr(A_CTRL, 32'h0000_0020);
    endtask

    task automatic t_rate();
        logic [31:0] d;
        wr(A_CTRL, 32'h20);           // P=0, D=16
        wr(A_CNT, 32'd5);
        wait_edges(15); rd(A_CNT, d); chk("R3 D16 before", d, 32'd5);
        wait_edges(1);  rd(A_CNT, d); chk("R3 D16 step", d, 32'd4);
        wr(A_CTRL, 32'h128);          // P=1, D=32 -> 64
        wr(A_CNT, 32'd10);
        wait_edges(63); rd(A_CNT, d); chk("R3 P1 D32 before", d, 32'd10);
        wait_edges(1);  rd(A_CNT, d); chk("R3 P1 D32 step", d, 32'd9);
        wr(A_CTRL, 32'h38);           // P=0, D=128
        wr(A_CNT, 32'd3);
        wait_edges(127); rd(A_CNT, d); chk("R3 D128 before", d, 32'd3);
        wait_edges(1);   rd(A_CNT, d); chk("R3 D128 step", d, 32'd2);
    endtask

    task automatic t_reload_write();
        logic [31:0] d;
        wr(A_CTRL, 32'h20);
        wr(A_RLD, 32'd9);
        wr(A_CNT, 32'd4);             // E0
        wr(A_RLD, 32'd3);             // E1
        rd(A_CNT, d); chk("R4 count kept", d, 32'd4);
        wait_edges(14); rd(A_CNT, d); chk("R4 before step", d, 32'd4);
        wait_edges(1);  rd(A_CNT, d); chk("R4 step", d, 32'd3);
        wait_edges(64); rd(A_CNT, d); chk("R4 new reload used", d, 32'd3);
    endtask

    task automatic t_terminal();
        logic [31:0] d;
        wr(A_CTRL, 32'h25);
        wr(A_CLR, 32'd0);
        wr(A_RLD, 32'd2);
        wr(A_CNT, 32'd0);
        wait_edges(15);
        chk("R6 no early pulse", {31'd0, rst_req_o}, 32'd0);
        rd(A_CNT, d); chk("R5 at zero", d, 32'd0);
        wait_edges(1);
        chk("R6 pulse", {31'd0, rst_req_o}, 32'd1);
        chk("R7 irq set", {31'd0, irq_o}, 32'd1);
        rd(A_CNT, d); chk("R5 reloaded", d, 32'd2);
        wait_edges(1);
        chk("R6 one cycle", {31'd0, rst_req_o}, 32'd0);
        chk("R7 irq held", {31'd0, irq_o}, 32'd1);
        wr(A_CLR, 32'hDEAD);
        chk("R7 cleared", {31'd0, irq_o}, 32'd0);
        // clear write on the terminal edge: set must win
        wr(A_CNT, 32'd0);
        wait_edges(15);
        wr(A_CLR, 32'h1);
        chk("R7 set wins over clear", {31'd0, irq_o}, 32'd1);
        // reset only, interrupt disabled
        wr(A_CTRL, 32'h21);
        wr(A_CLR, 32'd0);
        wr(A_RLD, 32'd1);
        wr(A_CNT, 32'd1);
        wait_edges(32);
        chk("R6 pulse rst-only", {31'd0, rst_req_o}, 32'd1);
        chk("R7 no irq when disabled", {31'd0, irq_o}, 32'd0);
        wait_edges(32);
        chk("R5 repeats", {31'd0, rst_req_o}, 32'd1);
        rd(A_CNT, d); chk("R5 reload again", d, 32'd1);
        // interrupt only
        wr(A_CTRL, 32'h24);
        wr(A_CNT, 32'd0);
        wait_edges(16);
        chk("R6 no pulse when disabled", {31'd0, rst_req_o}, 32'd0);
        chk("R7 irq only", {31'd0, irq_o}, 32'd1);
        wr(A_CLR, 32'd0);
    endtask

    task automatic t_debug();
        wr(A_CTRL, 32'h0001_0025);
        @(negedge clk); dbg_ack = 1'b1;
        wr(A_CNT, 32'd0);
        wait_edges(16);
        chk("R8 rst hidden", {31'd0, rst_req_o}, 32'd0);
        chk("R8 irq hidden", {31'd0, irq_o}, 32'd0);
        dbg_ack = 1'b0; #1;
        chk("R8 pending kept", {31'd0, irq_o}, 32'd1);
        dbg_ack = 1'b1; #1;
        chk("R8 hidden again", {31'd0, irq_o}, 32'd0);
        wr(A_CTRL, 32'h25);
        chk("R8 mask bit off", {31'd0, irq_o}, 32'd1);
        dbg_ack = 1'b0;
        wr(A_CLR, 32'd0);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        wr(A_CTRL, 32'h00);
        wr(A_CNT, 32'd7);
        wait_edges(40); rd(A_CNT, d); chk("R9 frozen", d, 32'd7);
        wr(A_CTRL, 32'h20);
        wait_edges(15); rd(A_CNT, d); chk("R9 restart before", d, 32'd7);
        wait_edges(1);  rd(A_CNT, d); chk("R9 restart step", d, 32'd6);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs();
        t_rate();
        t_reload_write();
        t_terminal();
        t_debug();
        t_stop();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule